// File: doc/BRIEF.md
# Wrapping Burst Line Memory Responder

This block is the memory end of a synchronous 32-bit bus. It serves cache-line transfers of four long words, and it also serves single long-word transfers. A requester presents an address, a 2-bit transfer kind, a direction and a burst flag together with a one-cycle start strobe. It then keeps the address steady until the transfer completes. The responder answers with one acknowledge per beat. On a read, the data word is valid in the same cycle as its acknowledge. On a write, the data word is taken in that same cycle.

A burst begins at the long word that the address points to. It steps upward through the line and wraps around past the last word. Every burst moves all four words of the line, even when the first word is in the middle of the line. Writes use the same order as reads.

Storage is a small register file of `LINES` lines of four words each, cleared by reset. Requests for the alternate space or for an interrupt acknowledge belong to other responders on the bus, so this block ignores them.

Top module: `bl_line_responder`

## Requirements
- R1: After synchronous reset `ack_o` is low and every stored word reads as zero.
- R2: An accepted burst read raises `ack_o` for four consecutive cycles, starting in the cycle after the start strobe. The requester must hold `addr_i` constant while `ack_o` is high.
- R3: In beat n of a burst, the word at line offset (s + n) mod 4 is read or written, where s is `addr_i[3:2]`. On a write, the word stored is the `wdata_i` present in that beat's acknowledge cycle.
- R4: Every burst moves exactly four words, whatever the start offset, and then `ack_o` drops.
- R5: Kind codes 00 (normal) and 01 (line move) are served in the same way. Codes 10 (alternate space) and 11 (interrupt acknowledge) produce no acknowledge and leave the storage unchanged.
- R6: A request with `burst_i` low moves one word, at offset `addr_i[3:2]`, with a single acknowledge.
- R7: A start strobe is ignored in any cycle in which `ack_o` is high.
- R8: The line is selected by `addr_i[LINE_W+3:4]`. Address bits [1:0] and the bits above the line field do not affect which word is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request strobe |
| addr_i | input | 32 | Byte address of the first word; held during the transfer |
| kind_i | input | 2 | Transfer kind: 00 normal, 01 line move, 10 alternate space, 11 interrupt acknowledge |
| wr_i | input | 1 | 1 = write, 0 = read |
| burst_i | input | 1 | 1 = four-word line burst, 0 = single word |
| wdata_i | input | 32 | Write data for the current beat |
| rdata_o | output | 32 | Read data, valid while `ack_o` is high |
| ack_o | output | 1 | Beat acknowledge |

## Verification
The hardest case to reach from the ports is a second start strobe that arrives in the middle of a running burst. The strobe is ignored, so the only evidence is the absence of extra beats and the absence of a stray write. The stimulus raises the strobe during the second beat of a read burst, requesting a write at the same address. A scoreboard then flags any acknowledge it did not expect, and a later read-back shows that the line is unchanged. Mid-line wrap is reached by starting bursts at offsets 1, 2 and 3 and comparing each beat against a model of the line.

// File: rtl/bl_pkg.sv
package bl_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned OFF_W  = 2;
    localparam int unsigned BEATS  = 4;

    typedef enum logic [1:0] {
        XK_NORMAL   = 2'b00,
        XK_LINEMOVE = 2'b01,
        XK_ALTSPACE = 2'b10,
        XK_INTACK   = 2'b11
    } xfer_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              burst;
    } bl_req_t;

    function automatic logic kind_serviced(input logic [1:0] k);
        xfer_kind_e e;
        e = xfer_kind_e'(k);
        return (e == XK_NORMAL) || (e == XK_LINEMOVE);
    endfunction

    function automatic logic [OFF_W-1:0] wrap_off(input logic [OFF_W-1:0] s,
                                                  input logic [OFF_W-1:0] n);
        return s + n;
    endfunction
endpackage

// File: rtl/bl_beat_seq.sv
module bl_beat_seq
    import bl_pkg::*;
#(
    parameter int unsigned LINES = 16,
    localparam int unsigned LINE_W = $clog2(LINES),
    localparam int unsigned IDX_W  = LINE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        kind_i,
    input  logic              wr_i,
    input  logic              burst_i,
    output logic              beat_o,
    output logic              we_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(BEATS - 1);

    bl_req_t          req_q;
    logic             busy_q;
    logic [OFF_W-1:0] cnt_q;
    logic [OFF_W-1:0] last_q;
    logic             accept;

    assign accept = start_i && !busy_q && kind_serviced(kind_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            busy_q <= 1'b0;
            cnt_q  <= '0;
            last_q <= '0;
        end else if (accept) begin
            req_q  <= '{addr: addr_i, wr: wr_i, burst: burst_i};
            busy_q <= 1'b1;
            cnt_q  <= '0;
            last_q <= burst_i ? LAST_BEAT : '0;
        end else if (busy_q) begin
            if (cnt_q == last_q) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign beat_o = busy_q;
    assign we_o   = busy_q && req_q.wr;
    assign idx_o  = {req_q.addr[LINE_W+3:4], wrap_off(req_q.addr[3:2], cnt_q)};

    // R2
    accept_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_q && kind_serviced(kind_i)) |=> busy_q);
    // R2
    addr_held_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (addr_i == req_q.addr));
    // R3
    wrap_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> (idx_o[OFF_W-1:0] == $past(idx_o[OFF_W-1:0]) + 1'b1));
    // R4
    four_beats_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && req_q.burst) |=> (busy_q == ($past(cnt_q) != LAST_BEAT)));
    // R5
    ignored_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_q && !kind_serviced(kind_i)) |=> !busy_q);
    // R6
    single_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !req_q.burst) |=> !busy_q);
endmodule

// File: rtl/bl_line_store.sv
module bl_line_store
    import bl_pkg::*;
#(
    parameter int unsigned LINES = 16,
    localparam int unsigned LINE_W = $clog2(LINES),
    localparam int unsigned IDX_W  = LINE_W + OFF_W,
    localparam int unsigned WORDS  = LINES * BEATS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o
);
    logic [WORD_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[idx_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/bl_line_responder.sv
module bl_line_responder
    import bl_pkg::*;
#(
    parameter int unsigned LINES = 16,
    localparam int unsigned LINE_W = $clog2(LINES),
    localparam int unsigned IDX_W  = LINE_W + OFF_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [31:0] addr_i,
    input  logic [1:0]  kind_i,
    input  logic        wr_i,
    input  logic        burst_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        ack_o
);
    logic             beat;
    logic             we;
    logic [IDX_W-1:0] idx;

    bl_beat_seq #(.LINES(LINES)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .addr_i  (addr_i),
        .kind_i  (kind_i),
        .wr_i    (wr_i),
        .burst_i (burst_i),
        .beat_o  (beat),
        .we_o    (we),
        .idx_o   (idx)
    );

    bl_line_store #(.LINES(LINES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we_i    (we),
        .idx_i   (idx),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o)
    );

    assign ack_o = beat;

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_o && start_i && $past(!ack_o)) |=> ack_o || $past(!burst_i));
endmodule

// File: tb/tb_bl_line_responder.sv
module tb_bl_line_responder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        start_i = 0;
    logic [31:0] addr_i = 0;
    logic [1:0]  kind_i = 0;
    logic        wr_i = 0;
    logic        burst_i = 0;
    logic [31:0] wdata_i = 0;
    logic [31:0] rdata_o;
    logic        ack_o;

    bl_line_responder dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit          is_rd;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t        expq[$];
    logic [31:0] model [64];
    int checks = 0;
    int fails = 0;
    int acks = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && ack_o && !done) begin
            acks++;
            if (expq.size() == 0) begin
                check(0, "R5 R7 unexpected ack", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (e.is_rd) check(rdata_o === e.data, e.tag, rdata_o, e.data);
                else         check(1'b1, e.tag, 32'h1, 32'h1);
            end
        end
    end

    task automatic xfer(input logic [31:0] a, input logic [1:0] k, input bit wr,
                        input bit bst, input logic [31:0] d [4], input string tag,
                        input bit poke);
        int n;
        n = bst ? 4 : 1;
        @(negedge clk);
        addr_i = a; kind_i = k; wr_i = wr; burst_i = bst; start_i = 1;
        if (k < 2) begin
            for (int i = 0; i < n; i++) begin
                int idx;
                idx = {a[7:4], 2'(a[3:2] + i)};
                if (wr) begin
                    model[idx] = d[i];
                    expq.push_back('{0, d[i], tag});
                end else begin
                    expq.push_back('{1, model[idx], tag});
                end
            end
        end
        @(negedge clk);
        start_i = 0; wdata_i = d[0];
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            wdata_i = d[i];
            if (poke && i == 1) begin
                start_i = 1; wr_i = 1; burst_i = 0; kind_i = 0;
            end else begin
                start_i = 0;
            end
        end
        @(negedge clk);
        start_i = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] z [4];
        logic [31:0] d [4];
        int a0;
        z = '{0, 0, 0, 0};
        for (int i = 0; i < 64; i++) model[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        check(ack_o === 1'b0, "R1 ack low after reset", {31'b0, ack_o}, 32'h0);

        // R1: unwritten line reads zero
        xfer(32'h0000_0058, 2'b00, 0, 1, z, "R1 reset contents", 0);

        // R3: write burst from offset 0, R2 read back
        d = '{32'hA000_0000, 32'hA000_0001, 32'hA000_0002, 32'hA000_0003};
        xfer(32'h0000_0030, 2'b00, 1, 1, d, "R3 write order", 0);
        xfer(32'h0000_0030, 2'b00, 0, 1, z, "R2 burst read", 0);

        // R4: start mid-line, wrap
        d = '{32'hB000_0003, 32'hB000_0000, 32'hB000_0001, 32'hB000_0002};
        xfer(32'h0000_002C, 2'b00, 1, 1, d, "R4 write wrap from 3", 0);
        xfer(32'h0000_0024, 2'b00, 0, 1, z, "R4 read wrap from 1", 0);
        xfer(32'h0000_0028, 2'b00, 0, 1, z, "R3 read wrap from 2", 0);

        // R5: line-move kind served like normal
        d = '{32'hC000_0001, 32'hC000_0002, 32'hC000_0003, 32'hC000_0000};
        xfer(32'h0000_0044, 2'b01, 1, 1, d, "R5 line move write", 0);
        xfer(32'h0000_0040, 2'b01, 0, 1, z, "R5 line move read", 0);

        // R5: alternate space and interrupt acknowledge ignored
        a0 = acks;
        d = '{32'hDEAD_0000, 32'hDEAD_0001, 32'hDEAD_0002, 32'hDEAD_0003};
        xfer(32'h0000_0030, 2'b10, 1, 1, d, "R5 alt write", 0);
        xfer(32'h0000_0030, 2'b11, 0, 0, z, "R5 intack", 0);
        check(acks == a0, "R5 no ack for ignored kinds", acks, a0);
        xfer(32'h0000_0030, 2'b00, 0, 1, z, "R5 line unchanged", 0);

        // R6: single-word write and read
        d = '{32'hE000_0002, 0, 0, 0};
        a0 = acks;
        xfer(32'h0000_0068, 2'b00, 1, 0, d, "R6 single write", 0);
        check(acks == a0 + 1, "R6 single ack", acks, a0 + 1);
        xfer(32'h0000_0060, 2'b00, 0, 1, z, "R6 only one word written", 0);
        a0 = acks;
        xfer(32'h0000_0068, 2'b00, 0, 0, z, "R6 single read", 0);
        check(acks == a0 + 1, "R6 single read ack", acks, a0 + 1);

        // R7: start during burst ignored
        a0 = acks;
        d = '{32'hF000_0000, 32'hF000_0001, 32'hF000_0002, 32'hF000_0003};
        xfer(32'h0000_0034, 2'b00, 0, 1, d, "R7 read with poke", 1);
        check(acks == a0 + 4, "R7 beat count", acks, a0 + 4);
        xfer(32'h0000_0030, 2'b00, 0, 1, z, "R7 no stray write", 0);

        // R8: byte bits and upper bits do not affect the word
        xfer(32'h0000_0027, 2'b00, 0, 1, z, "R8 byte bits ignored", 0);
        xfer(32'h1234_5F30, 2'b00, 0, 1, z, "R8 upper bits alias", 0);

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R4 all expected beats seen", expq.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule